// File: doc/BRIEF.md
# Depth-Split Output Stitching Merger

A convolution layer can have more kernels than the weight store holds. It is then computed in several passes, and each pass yields one equal slice of every output pixel's depth. Results travel depth-first: a pixel's full depth is sent before the next pixel starts. This block rebuilds each pixel as later passes arrive. The slices already assembled come in on a stitch stream, which carries the previous pass's output. The slice computed in the current pass comes in on a result stream. The block emits the combined pixel on its output stream. Two full-size buffers outside the block swap roles between passes: one is read as the stitch input while the other receives the output.

Each pass is configured with a single start pulse. The pulse carries the total depth, the number of splits, the index of the current pass (counting from 0) and the number of pixels. On pass k the block forwards k slices of stitch data for each pixel and then one slice of result data. On pass 0 it forwards only the result slice and never reads the stitch stream. A configuration is rejected, and a sticky error flag is raised, when it cannot be split evenly or does not name a valid pass.

Top module: `stitch_merge`

## Requirements
- R1: After reset, out_valid, busy, cfg_err, stitch_ready and res_ready are all 0.
- R2: On pass 0, each pixel's output is exactly depth/splits elements taken from the result stream, and stitch_ready stays 0 for the whole pass.
- R3: On pass k > 0, each pixel's output is k*(depth/splits) elements from the stitch stream in arrival order, followed by depth/splits elements from the result stream.
- R4: stitch_ready is asserted only while the current pixel is in its old-slice portion, and res_ready only while it is in its new-slice portion. The two are never high together, and both are 0 while the block is idle.
- R5: out_last is 1 on the final element of the final pixel of a pass, and 0 on every other output element.
- R6: A start is rejected when splits is 0, depth is 0, pixels is 0, pass is not less than splits, or depth is not a multiple of splits. A rejected start leaves busy at 0 and sets cfg_err one clock later. cfg_err stays set until reset and does not block later valid starts.
- R7: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.
- R8: A valid start taken while idle raises busy on the next clock. A start pulse while busy is ignored, and the running pass completes unchanged.
- R9: Every input element accepted is emitted exactly once and in order. After the final element, busy is 0 and no further output appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Start pulse; configuration is sampled with it |
| cfg_depth | input | DEPTH_W | Total output depth per pixel |
| cfg_splits | input | DEPTH_W | Number of passes the layer is split into |
| cfg_pass | input | DEPTH_W | Index of the current pass, from 0 |
| cfg_pixels | input | PIX_W | Number of pixels in the pass |
| busy | output | 1 | A pass is in progress |
| cfg_err | output | 1 | Sticky rejected-configuration flag |
| stitch_valid | input | 1 | Stitch stream element valid |
| stitch_ready | output | 1 | Stitch stream element accepted |
| stitch_data | input | DATA_W | Stitch stream element |
| res_valid | input | 1 | Result stream element valid |
| res_ready | output | 1 | Result stream element accepted |
| res_data | input | DATA_W | Result stream element |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Output consumer ready |
| out_data | output | DATA_W | Output element |
| out_last | output | 1 | Final element of the pass |

## Verification
An input element accepted on a clock edge shows up on out_data after that same edge, so it is visible one cycle after the handshake. busy and cfg_err change on the edge that samples the start pulse. The bench drives every input on the falling edge and lets the logic settle for a short delay. It then reads valid and ready, which are the handshakes that the next rising edge will complete. The scoreboard pops one expected element for each output handshake seen this way, and busy and cfg_err are read one falling edge after the start pulse. Hold behaviour under backpressure is checked by comparing the output sampled at the previous falling edge whenever the consumer stalled.

// File: rtl/stitch_pkg.sv
package stitch_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_OLD  = 2'd1,
    PH_NEW  = 2'd2
  } phase_t;
endpackage

// File: rtl/stitch_cfg_check.sv
module stitch_cfg_check #(
  parameter int DEPTH_W = 8
) (
  input  logic [DEPTH_W-1:0] depth,
  input  logic [DEPTH_W-1:0] splits,
  input  logic [DEPTH_W-1:0] pass_idx,
  output logic               ok,
  output logic [DEPTH_W-1:0] slice,
  output logic [DEPTH_W-1:0] old_len
);
  localparam int PW = 2 * DEPTH_W;
  logic [PW-1:0] prod;

  always_comb begin
    slice   = (splits != '0) ? depth / splits : '0;
    prod    = {{DEPTH_W{1'b0}}, slice} * {{DEPTH_W{1'b0}}, splits};
    old_len = DEPTH_W'(pass_idx * slice);
    ok      = (splits != '0) && (depth != '0) && (pass_idx < splits) &&
              (prod == {{DEPTH_W{1'b0}}, depth});
  end
endmodule

// File: rtl/stitch_seq.sv
module stitch_seq
  import stitch_pkg::*;
#(
  parameter int DEPTH_W = 8,
  parameter int PIX_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [DEPTH_W-1:0] slice,
  input  logic [DEPTH_W-1:0] old_len,
  input  logic [PIX_W-1:0]   pixels,
  input  logic               step,
  output phase_t             phase,
  output logic               fin
);
  logic [DEPTH_W-1:0] ecnt, slice_r, old_r;
  logic [PIX_W-1:0]   pcnt, pix_r;
  logic               end_old, end_new, end_pix;

  always_comb begin
    end_old = (ecnt == old_r - 1'b1);
    end_new = (ecnt == slice_r - 1'b1);
    end_pix = (pcnt == pix_r - 1'b1);
    fin     = (phase == PH_NEW) && end_new && end_pix;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      ecnt    <= '0;
      pcnt    <= '0;
      slice_r <= '0;
      old_r   <= '0;
      pix_r   <= '0;
    end else if (phase == PH_IDLE) begin
      if (load) begin
        slice_r <= slice;
        old_r   <= old_len;
        pix_r   <= pixels;
        ecnt    <= '0;
        pcnt    <= '0;
        phase   <= (old_len != '0) ? PH_OLD : PH_NEW;
      end
    end else if (step) begin
      if (phase == PH_OLD) begin
        if (end_old) begin
          ecnt  <= '0;
          phase <= PH_NEW;
        end else begin
          ecnt <= ecnt + 1'b1;
        end
      end else begin
        if (end_new) begin
          ecnt <= '0;
          if (end_pix) begin
            phase <= PH_IDLE;
          end else begin
            pcnt  <= pcnt + 1'b1;
            phase <= (old_r != '0) ? PH_OLD : PH_NEW;
          end
        end else begin
          ecnt <= ecnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stitch_out_reg.sv
module stitch_out_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              slot_free,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_last,
  input  logic              out_ready
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (slot_free) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data <= in_data;
        out_last <= in_last;
      end
    end
  end
endmodule

// File: rtl/stitch_merge.sv
module stitch_merge
  import stitch_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH_W = 8,
  parameter int PIX_W   = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_start,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic [DEPTH_W-1:0] cfg_splits,
  input  logic [DEPTH_W-1:0] cfg_pass,
  input  logic [PIX_W-1:0]   cfg_pixels,
  output logic               busy,
  output logic               cfg_err,
  input  logic               stitch_valid,
  output logic               stitch_ready,
  input  logic [DATA_W-1:0]  stitch_data,
  input  logic               res_valid,
  output logic               res_ready,
  input  logic [DATA_W-1:0]  res_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  output logic               out_last
);
  logic               cfg_ok, load, reject, slot_free, src_valid, step, fin;
  logic [DEPTH_W-1:0] slice, old_len;
  logic [DATA_W-1:0]  src_data;
  phase_t             phase;

  stitch_cfg_check #(.DEPTH_W(DEPTH_W)) u_chk_cfg (
    .depth(cfg_depth), .splits(cfg_splits), .pass_idx(cfg_pass),
    .ok(cfg_ok), .slice(slice), .old_len(old_len)
  );

  assign busy   = (phase != PH_IDLE);
  assign load   = cfg_start && !busy && cfg_ok && (cfg_pixels != '0);
  assign reject = cfg_start && !busy && !(cfg_ok && (cfg_pixels != '0));

  stitch_seq #(.DEPTH_W(DEPTH_W), .PIX_W(PIX_W)) u_seq (
    .clk(clk), .rst(rst), .load(load), .slice(slice), .old_len(old_len),
    .pixels(cfg_pixels), .step(step), .phase(phase), .fin(fin)
  );

  always_comb begin
    stitch_ready = (phase == PH_OLD) && slot_free;
    res_ready    = (phase == PH_NEW) && slot_free;
    src_valid    = ((phase == PH_OLD) && stitch_valid) ||
                   ((phase == PH_NEW) && res_valid);
    src_data     = (phase == PH_OLD) ? stitch_data : res_data;
    step         = src_valid && slot_free;
  end

  stitch_out_reg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .in_valid(src_valid), .in_data(src_data),
    .in_last(fin), .slot_free(slot_free), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .out_ready(out_ready)
  );

  always_ff @(posedge clk) begin
    if (rst)         cfg_err <= 1'b0;
    else if (reject) cfg_err <= 1'b1;
  end
endmodule

// File: rtl/stitch_merge_chk.sv
module stitch_merge_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              cfg_err,
  input logic              stitch_ready,
  input logic              res_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_last
);
  // R7: stalled output holds
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R4: the two input streams are never accepted together
  p_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(stitch_ready && res_ready));
  // R4: no input accepted while idle
  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !stitch_ready && !res_ready);
  // R6: error flag is sticky
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
  // R5: last marker only on a valid element, and only once the pass is over
  p_last_r5: assert property (@(posedge clk) disable iff (rst)
    out_last && out_valid && $rose(out_valid) |-> !busy);
  p_lastv_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(out_last) |-> out_valid);
endmodule

bind stitch_merge stitch_merge_chk #(.DATA_W(DATA_W)) u_stitch_merge_chk (
  .clk(clk), .rst(rst), .busy(busy), .cfg_err(cfg_err),
  .stitch_ready(stitch_ready), .res_ready(res_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
);

// File: tb/stitch_merge_bench.sv
module stitch_merge_bench;
  localparam int DW = 16;
  localparam int CW = 8;
  localparam int PW = 10;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_start;
  logic [CW-1:0] cfg_depth, cfg_splits, cfg_pass;
  logic [PW-1:0] cfg_pixels;
  logic          busy, cfg_err;
  logic          stitch_valid, stitch_ready, res_valid, res_ready;
  logic [DW-1:0] stitch_data, res_data, out_data;
  logic          out_valid, out_ready, out_last;

  int n_checks = 0;
  int n_fail   = 0;

  logic [DW-1:0] sq[$];
  logic [DW-1:0] rq[$];
  logic [DW:0]   exq[$];

  always #5 clk = ~clk;

  stitch_merge #(.DATA_W(DW), .DEPTH_W(CW), .PIX_W(PW)) u_stitch_merge (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_depth(cfg_depth),
    .cfg_splits(cfg_splits), .cfg_pass(cfg_pass), .cfg_pixels(cfg_pixels),
    .busy(busy), .cfg_err(cfg_err), .stitch_valid(stitch_valid),
    .stitch_ready(stitch_ready), .stitch_data(stitch_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    finish_run();
  end

  task automatic do_reset();
    rst = 1'b1; cfg_start = 1'b0; stitch_valid = 1'b0; res_valid = 1'b0;
    out_ready = 1'b1; stitch_data = '0; res_data = '0;
    cfg_depth = '0; cfg_splits = '0; cfg_pass = '0; cfg_pixels = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Driver: builds expected items, feeds both streams, monitor pops and compares
  task automatic run_pass(input int depth, input int splits, input int pidx,
                          input int pixels, input bit stall, input bit poke);
    int slice = depth / splits;
    int olen  = pidx * slice;
    int sidx = 0, ridx = 0, k = 0;
    bit held = 1'b0, stitch_seen = 1'b0, both_seen = 1'b0;
    logic [DW:0] hd = '0;
    logic [DW:0] e;
    sq.delete(); rq.delete(); exq.delete();
    for (int p = 0; p < pixels; p++) begin
      for (int i = 0; i < olen; i++) begin
        sq.push_back(DW'(16'h4000 | (p << 7) | i));
        exq.push_back({1'b0, DW'(16'h4000 | (p << 7) | i)});
      end
      for (int i = 0; i < slice; i++) begin
        rq.push_back(DW'(16'h8000 | (p << 7) | i));
        exq.push_back({(p == pixels - 1) && (i == slice - 1), DW'(16'h8000 | (p << 7) | i)});
      end
    end
    cfg_depth = CW'(depth); cfg_splits = CW'(splits); cfg_pass = CW'(pidx);
    cfg_pixels = PW'(pixels); cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(busy == 1'b1, "R8 busy after start", busy, 1);
    while (exq.size() != 0 && k < 5000) begin
      k++;
      stitch_valid = (sidx < sq.size()) && !(stall && (k % 3 == 1));
      stitch_data  = (sidx < sq.size()) ? sq[sidx] : '0;
      res_valid    = (ridx < rq.size()) && !(stall && (k % 5 == 2));
      res_data     = (ridx < rq.size()) ? rq[ridx] : '0;
      out_ready    = !(stall && (k % 4 == 3));
      if (poke && k == 4) begin
        cfg_start = 1'b1; cfg_depth = 8'd3; cfg_splits = 8'd1;
        cfg_pass = 8'd0; cfg_pixels = 10'd1;
      end else begin
        cfg_start = 1'b0;
      end
      #1;
      if (held) chk(out_valid && ({out_last, out_data} == hd), "R7 hold",
                    int'({out_last, out_data}), int'(hd));
      held = out_valid && !out_ready;
      hd   = {out_last, out_data};
      if (stitch_ready) stitch_seen = 1'b1;
      if (stitch_ready && res_ready) both_seen = 1'b1;
      if (stitch_valid && stitch_ready) sidx++;
      if (res_valid && res_ready) ridx++;
      if (out_valid && out_ready) begin
        e = exq.pop_front();
        chk({out_last, out_data} == e, pidx == 0 ? "R2 data" : "R3/R5 data",
            int'({out_last, out_data}), int'(e));
      end
      @(negedge clk);
    end
    stitch_valid = 1'b0; res_valid = 1'b0; out_ready = 1'b1; cfg_start = 1'b0;
    chk(exq.size() == 0, "R9 all emitted", exq.size(), 0);
    chk(sidx == sq.size() && ridx == rq.size(), "R9 all consumed", sidx + ridx,
        sq.size() + rq.size());
    if (pidx == 0) chk(!stitch_seen, "R2 stitch idle", stitch_seen, 0);
    chk(!both_seen, "R4 exclusive ready", both_seen, 0);
    repeat (2) @(negedge clk);
    chk(!busy && !out_valid, "R9 no extra output", {busy, out_valid}, 0);
  endtask

  task automatic bad_cfg(input int depth, input int splits, input int pidx, input int pixels);
    cfg_depth = CW'(depth); cfg_splits = CW'(splits); cfg_pass = CW'(pidx);
    cfg_pixels = PW'(pixels); cfg_start = 1'b1;
    @(negedge clk);
    cfg_start = 1'b0;
    chk(!busy && cfg_err, "R6 reject", {busy, cfg_err}, 1);
    chk(!stitch_ready && !res_ready, "R4 idle readies", {stitch_ready, res_ready}, 0);
  endtask

  initial begin
    do_reset();
    // R1
    chk(!out_valid && !busy && !cfg_err && !stitch_ready && !res_ready, "R1 reset",
        {out_valid, busy, cfg_err, stitch_ready, res_ready}, 0);
    run_pass(12, 3, 0, 3, 1'b0, 1'b0);   // R2 first pass
    run_pass(12, 3, 1, 3, 1'b1, 1'b0);   // R3 middle pass with stalls, R7
    run_pass(12, 3, 2, 2, 1'b1, 1'b1);   // R3 final pass, R8 start ignored
    run_pass(5, 1, 0, 1, 1'b0, 1'b0);    // R5 single pixel, single slice
    run_pass(16, 4, 3, 4, 1'b0, 1'b0);   // R3 deepest pass without stalls
    chk(!cfg_err, "R6 no error yet", cfg_err, 0);
    bad_cfg(10, 4, 0, 2);                // R6 uneven depth
    bad_cfg(8, 0, 0, 2);                 // R6 zero splits
    bad_cfg(9, 3, 3, 2);                 // R6 pass out of range
    bad_cfg(9, 3, 0, 0);                 // R6 no pixels
    run_pass(8, 2, 1, 2, 1'b1, 1'b0);    // R6 valid start after error
    chk(cfg_err, "R6 sticky", cfg_err, 1);
    do_reset();
    chk(!cfg_err, "R1 error cleared by reset", cfg_err, 0);
    finish_run();
  end
endmodule